// File: doc/BRIEF.md
# Range-Gated Flash Converter Back End

This block is the digital back end of a 6-bit flash converter. The converter's 64 comparators are split into four groups of 16, and only one group is clocked per sample to save power. A window detector for each group reports whether the input lies inside that group's voltage span. The block turns those four window results into one strobe enable per group. It also selects the 16 decisions of the chosen group and rebuilds a full 64-bit thermometer code from them.

The rebuilt code passes through a three-input bubble filter that yields a one-hot word. A ROM-style encoder maps that word to binary, and the 6-bit result is registered. A valid bit runs alongside the data with a fixed two-cycle latency.

When no window reports a hit, the output saturates to the bottom or top code, chosen by an overrange input, and an error bit is raised for that sample. When several windows report a hit, the highest group wins.

Top module: `gated_flash_encoder`

## Requirements
- R1: Group g counts as flagged only when both `win_above[g]` and `win_below[g]` are 1; a group with only one of the two set is treated as not flagged.
- R2: `strobe_en` is combinational from the window inputs. It has exactly one bit set, at the selected group, when any group is flagged, and it is all zeros when none is.
- R3: Comparator bit `cmp_dec[16*g+j]` is comparator j of group g, with a higher j meaning a higher reference. If group g is selected with its lowest k comparators set (k from 0 to 16), the rebuilt thermometer has all bits of lower groups set and all bits of higher groups clear. The output code is then 16*g+k-1 for k≥1, 16*g-1 for k=0 and g>0, and 0 for k=0 and g=0.
- R4: The bubble filter sets one-hot bit i when thermometer bits i-1 and i are 1 and bit i+1 is 0. Position -1 reads as 1 and position 64 reads as 0, so a lone 1 above a gap is suppressed.
- R5: The output code is the bitwise OR of the indices of all set one-hot bits, and 0 when no one-hot bit is set.
- R6: Decision bits of the groups that are not selected have no effect on the output code, even when they change every cycle.
- R7: When no group is flagged in a valid sample, `out_err` is 1 for that sample. The code is then 63 if `ovr_high` is 1 and 0 otherwise.
- R8: Outputs appear two clock edges after the inputs are sampled. `out_valid` equals `in_valid` from two cycles earlier, and `out_err` is 1 only when `out_valid` is 1.
- R9: While `rst` is held high, `out_valid`, `out_code` and `out_err` read 0 after the next clock edge.
- R10: When several groups are flagged at once, the highest-numbered flagged group is selected for both the strobe and the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Current inputs form a sample |
| win_above | input | 4 | Per group: input above the group's lower bound |
| win_below | input | 4 | Per group: input below the group's upper bound |
| ovr_high | input | 1 | Sticky overrange direction, 1 = above full scale |
| cmp_dec | input | 64 | Comparator decisions, 16 per group, group 0 lowest |
| strobe_en | output | 4 | Strobe enable, one bit per comparator group |
| out_valid | output | 1 | Registered sample valid |
| out_code | output | 6 | Registered binary code |
| out_err | output | 1 | No window flagged for this sample |

## Verification
The assertions assume that the window inputs, overrange input and valid bit are known, non-X values on every clock edge after reset. Saturation and error checks also assume that a sample's window inputs are the only ones that decide whether it flags a group. The stimulus always drives every input to a defined value at the falling edge and releases reset only after both pipeline stages are cleared. Decision words for unselected groups are deliberately randomised to exercise the don't-care path, while the window pairs are chosen so that single, multiple, half-set and empty flag patterns all occur.

// File: rtl/gfe_pkg.sv
package gfe_pkg;
    parameter int RES_W   = 6;
    parameter int NGRP    = 4;
    parameter int GRP_W   = 16;
    localparam int THERM_W = NGRP * GRP_W;
    localparam int SEL_W   = $clog2(NGRP);

    typedef logic [SEL_W-1:0] grp_idx_t;

    // Stage-1 record: the selected group's slice and its context
    typedef struct packed {
        logic             vld;
        logic             none;
        logic             ovr;
        grp_idx_t         grp;
        logic [GRP_W-1:0] bits;
    } s1_t;

    // Stage-2 record: registered result
    typedef struct packed {
        logic             vld;
        logic             err;
        logic [RES_W-1:0] code;
    } s2_t;

    // Expand one group's decisions into the full thermometer word
    function automatic logic [THERM_W-1:0] rebuild_therm(
        input grp_idx_t         grp,
        input logic [GRP_W-1:0] bits
    );
        logic [THERM_W-1:0] t;
        t = '0;
        for (int g = 0; g < NGRP; g++) begin
            if (g < int'(grp))
                t[g*GRP_W +: GRP_W] = '1;
            else if (g == int'(grp))
                t[g*GRP_W +: GRP_W] = bits;
            else
                t[g*GRP_W +: GRP_W] = '0;
        end
        return t;
    endfunction
endpackage

// File: rtl/gfe_window.sv
module gfe_window #(
    parameter int NGRP = gfe_pkg::NGRP
) (
    input  logic [NGRP-1:0] above,
    input  logic [NGRP-1:0] below,
    output logic [NGRP-1:0] flag
);
    for (genvar g = 0; g < NGRP; g++) begin : g_win
        assign flag[g] = above[g] & below[g];
    end
endmodule

// File: rtl/gfe_select.sv
module gfe_select #(
    parameter int NGRP  = gfe_pkg::NGRP,
    localparam int SEL_W = $clog2(NGRP)
) (
    input  logic [NGRP-1:0]  flag,
    output logic [SEL_W-1:0] idx,
    output logic             none,
    output logic [NGRP-1:0]  strobe
);
    // Ascending scan: the last hit, i.e. the highest group, wins
    always_comb begin
        idx  = '0;
        none = 1'b1;
        for (int g = 0; g < NGRP; g++) begin
            if (flag[g]) begin
                idx  = SEL_W'(g);
                none = 1'b0;
            end
        end
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_stb
        assign strobe[g] = !none && (idx == SEL_W'(g));
    end
endmodule

// File: rtl/gfe_bubble.sv
module gfe_bubble #(
    parameter int W = gfe_pkg::THERM_W
) (
    input  logic [W-1:0] therm,
    output logic [W-1:0] hot
);
    logic [W+1:0] padded;
    assign padded = {1'b0, therm, 1'b1};

    for (genvar i = 0; i < W; i++) begin : g_hot
        assign hot[i] = padded[i] & padded[i+1] & ~padded[i+2];
    end
endmodule

// File: rtl/gfe_rom.sv
module gfe_rom #(
    parameter int W     = gfe_pkg::THERM_W,
    parameter int OUT_W = gfe_pkg::RES_W
) (
    input  logic [W-1:0]     hot,
    output logic [OUT_W-1:0] code
);
    // Wired-OR rows: every active word line drives its own index
    always_comb begin
        code = '0;
        for (int i = 0; i < W; i++) begin
            if (hot[i])
                code = code | OUT_W'(i);
        end
    end
endmodule

// File: rtl/gated_flash_encoder.sv
module gated_flash_encoder
    import gfe_pkg::*;
#(
    parameter int NG  = NGRP,
    parameter int GW  = GRP_W,
    parameter int OW  = RES_W,
    localparam int TW = NG * GW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [NG-1:0] win_above,
    input  logic [NG-1:0] win_below,
    input  logic          ovr_high,
    input  logic [TW-1:0] cmp_dec,
    output logic [NG-1:0] strobe_en,
    output logic          out_valid,
    output logic [OW-1:0] out_code,
    output logic          out_err
);
    logic [NG-1:0] flag;
    grp_idx_t      sel_idx;
    logic          sel_none;
    s1_t           s1_d, s1_q;
    s2_t           s2_d, s2_q;
    logic [TW-1:0] therm;
    logic [TW-1:0] hot;
    logic [OW-1:0] rom_code;

    gfe_window #(.NGRP(NG)) u_win (
        .above (win_above),
        .below (win_below),
        .flag  (flag)
    );

    gfe_select #(.NGRP(NG)) u_sel (
        .flag   (flag),
        .idx    (sel_idx),
        .none   (sel_none),
        .strobe (strobe_en)
    );

    // Stage 1: capture only the selected group's slice
    always_comb begin
        s1_d.vld  = in_valid;
        s1_d.none = sel_none;
        s1_d.ovr  = ovr_high;
        s1_d.grp  = sel_idx;
        s1_d.bits = cmp_dec[sel_idx*GW +: GW];
    end

    always_ff @(posedge clk) begin
        if (rst) s1_q <= '0;
        else     s1_q <= s1_d;
    end

    // Stage 2: rebuild, filter, encode
    always_comb begin
        if (s1_q.none) therm = {TW{s1_q.ovr}};
        else           therm = rebuild_therm(s1_q.grp, s1_q.bits);
    end

    gfe_bubble #(.W(TW)) u_bub (
        .therm (therm),
        .hot   (hot)
    );

    gfe_rom #(.W(TW), .OUT_W(OW)) u_rom (
        .hot  (hot),
        .code (rom_code)
    );

    always_comb begin
        s2_d.vld  = s1_q.vld;
        s2_d.err  = s1_q.vld & s1_q.none;
        s2_d.code = rom_code;
    end

    always_ff @(posedge clk) begin
        if (rst) s2_q <= '0;
        else     s2_q <= s2_d;
    end

    assign out_valid = s2_q.vld;
    assign out_err   = s2_q.err;
    assign out_code  = s2_q.code;
endmodule

// File: rtl/gfe_checker.sv
module gfe_checker #(
    parameter int NG = gfe_pkg::NGRP,
    parameter int OW = gfe_pkg::RES_W
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [NG-1:0] win_above,
    input logic [NG-1:0] win_below,
    input logic          ovr_high,
    input logic [NG-1:0] strobe_en,
    input logic          out_valid,
    input logic [OW-1:0] out_code,
    input logic          out_err
);
    logic [NG-1:0] both;
    assign both = win_above & win_below;

    assert_strobe_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strobe_en));

    assert_strobe_in_window_R1: assert property (@(posedge clk) disable iff (rst)
        (strobe_en & ~both) == '0);

    assert_strobe_any_R2: assert property (@(posedge clk) disable iff (rst)
        (both != '0) |-> (strobe_en != '0));

    assert_top_wins_R10: assert property (@(posedge clk) disable iff (rst)
        both[NG-1] |-> strobe_en[NG-1]);

    assert_valid_latency_R8: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 out_valid);

    assert_err_needs_valid_R8: assert property (@(posedge clk) disable iff (rst)
        out_err |-> out_valid);

    assert_none_raises_err_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && both == '0) |-> ##2 out_err);

    assert_sat_high_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && both == '0 && ovr_high) |-> ##2 (out_code == '1));

    assert_sat_low_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && both == '0 && !ovr_high) |-> ##2 (out_code == '0));
endmodule

bind gated_flash_encoder gfe_checker #(.NG(NG), .OW(OW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .win_above (win_above),
    .win_below (win_below),
    .ovr_high  (ovr_high),
    .strobe_en (strobe_en),
    .out_valid (out_valid),
    .out_code  (out_code),
    .out_err   (out_err)
);

// File: tb/sim_gated_flash_encoder.sv
module sim_gated_flash_encoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  win_above = '0;
    logic [3:0]  win_below = '0;
    logic        ovr_high = 1'b0;
    logic [63:0] cmp_dec = '0;
    logic [3:0]  strobe_en;
    logic        out_valid;
    logic [5:0]  out_code;
    logic        out_err;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct packed {
        logic       v;
        logic       e;
        logic [5:0] c;
        logic [7:0] tag;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;

    gated_flash_encoder u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .win_above(win_above), .win_below(win_below), .ovr_high(ovr_high),
        .cmp_dec(cmp_dec), .strobe_en(strobe_en),
        .out_valid(out_valid), .out_code(out_code), .out_err(out_err)
    );

    // Highest group with both window halves set, -1 if none (R1, R10)
    function automatic int pick_group(input logic [3:0] a, input logic [3:0] b);
        int g;
        g = -1;
        for (int i = 0; i < 4; i++) if (a[i] && b[i]) g = i;
        return g;
    endfunction

    // Behavioural reference: {err, code} (R3, R4, R5, R7)
    function automatic logic [6:0] model(input logic [3:0] a, input logic [3:0] b,
                                         input logic o, input logic [63:0] d);
        int g;
        logic [65:0] t;
        logic [5:0] c;
        g = pick_group(a, b);
        if (g < 0) return {1'b1, (o ? 6'd63 : 6'd0)};
        t = '0;
        t[0] = 1'b1;
        for (int j = 0; j < 64; j++) begin
            if (j / 16 < g)       t[j+1] = 1'b1;
            else if (j / 16 > g)  t[j+1] = 1'b0;
            else                  t[j+1] = d[j];
        end
        c = '0;
        for (int i = 0; i < 64; i++)
            if (t[i] && t[i+1] && !t[i+2]) c = c | 6'(i);
        return {1'b0, c};
    endfunction

    task automatic check_out(input exp_t e);
        n_tests++;
        if (out_valid !== e.v || (e.v && (out_code !== e.c || out_err !== e.e))
            || (!e.v && out_err !== 1'b0)) begin
            n_fail++;
            $display("FAIL R%0d: valid/code/err = %0b/%0d/%0b expected %0b/%0d/%0b",
                     e.tag, out_valid, out_code, out_err, e.v, e.c, e.e);
        end
    endtask

    task automatic step(input logic v, input logic [3:0] a, input logic [3:0] b,
                        input logic o, input logic [63:0] d, input int tag);
        logic [6:0] m;
        int g;
        logic [3:0] se;
        exp_t e;
        @(negedge clk);
        if (q.size() >= 2) check_out(q.pop_front());
        in_valid = v; win_above = a; win_below = b; ovr_high = o; cmp_dec = d;
        #1;
        g  = pick_group(a, b);
        se = (g < 0) ? 4'b0 : (4'b1 << g);
        n_tests++;
        if (strobe_en !== se) begin
            n_fail++;
            $display("FAIL R1/R2/R10: strobe_en = %b expected %b", strobe_en, se);
        end
        m = model(a, b, o, d);
        e.v = v; e.e = v & m[6]; e.c = m[5:0]; e.tag = 8'(tag);
        q.push_back(e);
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] d;
        repeat (4) @(negedge clk);
        // R9: reset state
        n_tests++;
        if (out_valid !== 1'b0 || out_code !== 6'd0 || out_err !== 1'b0) begin
            n_fail++;
            $display("FAIL R9: valid/code/err = %0b/%0d/%0b expected 0/0/0",
                     out_valid, out_code, out_err);
        end
        rst = 1'b0;
        step(1'b0, 4'h0, 4'h0, 1'b0, '0, 9);
        step(1'b0, 4'h0, 4'h0, 1'b0, '0, 9);

        // R3: clean thermometer in each group, every fill level
        for (int g = 0; g < 4; g++)
            for (int k = 0; k <= 16; k++) begin
                d = rnd64();
                d[g*16 +: 16] = 16'((32'h1 << k) - 1);
                step(1'b1, 4'h1 << g, 4'h1 << g, 1'b0, d, 3);
            end

        // R4: lone 1 above a gap is suppressed; R5 ROM OR on a split run
        step(1'b1, 4'h2, 4'h2, 1'b0, {32'h0, 16'h0107, 16'h0}, 4);
        step(1'b1, 4'h1, 4'h1, 1'b0, {48'h0, 16'h8000}, 4);
        step(1'b1, 4'h4, 4'h4, 1'b0, {16'h0, 16'h00F7, 32'h0}, 5);
        step(1'b1, 4'h8, 4'h8, 1'b0, {16'hF0FF, 48'h0}, 5);

        // R6: unselected groups toggle, selected slice fixed
        for (int i = 0; i < 24; i++) begin
            d = rnd64();
            d[32 +: 16] = 16'h00FF;
            step(1'b1, 4'h4, 4'h4, 1'b0, d, 6);
        end

        // R7: no group flagged, both saturation directions
        step(1'b1, 4'h0, 4'hF, 1'b0, rnd64(), 7);
        step(1'b1, 4'hF, 4'h0, 1'b1, rnd64(), 7);
        step(1'b1, 4'h0, 4'h0, 1'b1, rnd64(), 7);
        // R1: halves set in different groups only
        step(1'b1, 4'h5, 4'hA, 1'b0, rnd64(), 1);

        // R10: several groups flagged
        step(1'b1, 4'h5, 4'h5, 1'b0, {16'h0, 16'h0FFF, 32'hFFFF_0003}, 10);
        step(1'b1, 4'hF, 4'h7, 1'b0, rnd64(), 10);

        // R8: valid gaps, including a no-flag cycle while idle
        step(1'b0, 4'h0, 4'h0, 1'b1, rnd64(), 8);
        step(1'b1, 4'h2, 4'h2, 1'b0, rnd64(), 8);
        step(1'b0, 4'h2, 4'h2, 1'b0, rnd64(), 8);

        // Random mix
        for (int i = 0; i < 3000; i++)
            step(1'($urandom_range(0, 3) != 0), 4'($urandom()), 4'($urandom()),
                 1'($urandom()), rnd64(), 8);

        step(1'b0, 4'h0, 4'h0, 1'b0, '0, 8);
        step(1'b0, 4'h0, 4'h0, 1'b0, '0, 8);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule